// File: doc/BRIEF.md
# Parity-checked serial nibble receiver

This block terminates a simple request/acknowledge link that carries 4-bit data pieces, each with an accompanying parity bit. When the sender raises its request, the receiver samples the piece and evaluates even parity. One cycle later it returns a one-cycle verdict on a 2-bit response output: acknowledge when the parity is good, error when it is not.

Pieces that pass the check are handed to a downstream word-assembly stage. The handoff is a single-cycle valid strobe with the nibble on a data bus, in the cycle after the acknowledge. The stage is pipelined: the cycle in which a piece is forwarded downstream can also be the cycle in which the next piece is sampled. A sender that presents pieces back to back therefore completes one two-cycle transaction after another with no idle gap.

The reset input is asynchronous and active low. Inside the block it is released through a small synchronizer, so the block starts taking requests a fixed number of edges after the reset pin rises.

Top module: `nib_rx`

## Requirements
- R1: A piece is good when the XOR of the four data bits and the parity bit is 0 (even parity over five bits); any other piece is bad.
- R2: The response output uses 2'b01 for acknowledge (good piece), 2'b10 for error (bad piece) and 2'b00 for idle; 2'b11 never appears.
- R3: A request seen high at a rising edge while the response output is idle produces the verdict in the following cycle, and the verdict lasts exactly one cycle.
- R4: A request seen during a cycle in which a verdict is being shown is ignored. A request held over both cycles of a transaction therefore yields exactly one verdict.
- R5: After an acknowledge, the downstream valid output is high for exactly the next cycle, and the forwarded data output carries the acknowledged nibble.
- R6: A piece answered with error is never forwarded: valid stays low in the cycle after the error, and the forwarded data output keeps its previous value.
- R7: A new piece may be sampled in the same cycle as the previous piece is forwarded. Back-to-back transactions then take two cycles each, with the new verdict in the cycle after the forward.
- R8: Driving the reset pin low clears the response output, the valid output, the held piece and the forwarded data output to zero at once, without waiting for a clock. Requests are taken again from the third rising edge after the pin returns high.
- R9: The forwarded data output holds the last forwarded nibble between valid pulses.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_i | input | 1 | Sender request: a piece is present on data_i/par_i |
| data_i | input | 4 | Data nibble from the sender |
| par_i | input | 1 | Parity bit making the five bits even when the piece is good |
| resp_o | output | 2 | Verdict: 00 idle, 01 acknowledge, 10 error |
| fwd_vld_o | output | 1 | One-cycle strobe to the word-assembly stage |
| fwd_data_o | output | 4 | Nibble forwarded downstream |

## Verification
The checker assumes that the sender keeps request, data and parity steady from the edge at which a piece is sampled until the verdict has been shown. The check that ties the forwarded nibble to the input two edges earlier relies on this. The bench changes its inputs only on falling edges. It starts a new piece only in the cycle after a verdict, either holding the old piece through the verdict cycle or dropping it there, so that the assumption always holds. The sweep covers all 32 data/parity combinations, mixing back-to-back, held-request and gapped transactions, and includes one reset asserted in the middle of a verdict.

// File: rtl/nib_rx_pkg.sv
package nib_rx_pkg;

  localparam int unsigned NIB_W = 4;

  typedef enum logic [1:0] {
    RSP_IDLE = 2'b00,
    RSP_ACK  = 2'b01,
    RSP_ERR  = 2'b10
  } rsp_e;

endpackage

// File: rtl/nib_rst_sync.sv
module nib_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/nib_par_chk.sv
module nib_par_chk #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] data,
  input  logic         par,
  output logic         good
);

  logic [W:0] chain;

  assign chain[0] = par;

  for (genvar i = 0; i < W; i++) begin : g_xor
    assign chain[i+1] = chain[i] ^ data[i];
  end

  assign good = ~chain[W];

endmodule

// File: rtl/nib_rx_resp.sv
module nib_rx_resp
  import nib_rx_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         req,
  input  logic [W-1:0] data,
  input  logic         good,
  output rsp_e         rsp,
  output logic [W-1:0] held
);

  rsp_e         rsp_q;
  rsp_e         rsp_d;
  logic [W-1:0] held_q;
  logic         busy;
  logic         take;
  logic         held_en;

  always_comb begin
    busy    = (rsp_q != RSP_IDLE);
    take    = req && !busy;
    held_en = take && good;
    if (!take) begin
      rsp_d = RSP_IDLE;
    end else if (good) begin
      rsp_d = RSP_ACK;
    end else begin
      rsp_d = RSP_ERR;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q <= RSP_IDLE;
    end else begin
      rsp_q <= rsp_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_q <= '0;
    end else if (held_en) begin
      held_q <= data;
    end
  end

  assign rsp  = rsp_q;
  assign held = held_q;

endmodule

// File: rtl/nib_rx_fwd.sv
module nib_rx_fwd
  import nib_rx_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  rsp_e         rsp,
  input  logic [W-1:0] held,
  output logic         vld,
  output logic [W-1:0] data
);

  logic         vld_q;
  logic         vld_d;
  logic [W-1:0] data_q;
  logic         fwd_en;

  always_comb begin
    fwd_en = (rsp == RSP_ACK);
    vld_d  = fwd_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
    end else begin
      vld_q <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (fwd_en) begin
      data_q <= held;
    end
  end

  assign vld  = vld_q;
  assign data = data_q;

endmodule

// File: rtl/nib_rx.sv
module nib_rx
  import nib_rx_pkg::*;
#(
  parameter int unsigned DATA_W      = NIB_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic [1:0]        resp_o,
  output logic              fwd_vld_o,
  output logic [DATA_W-1:0] fwd_data_o
);

  logic              rst_int_n;
  logic              good;
  rsp_e              rsp;
  logic [DATA_W-1:0] held;

  nib_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  nib_par_chk #(.W(DATA_W)) i_par_chk (
    .data (data_i),
    .par  (par_i),
    .good (good)
  );

  nib_rx_resp #(.W(DATA_W)) i_resp (
    .clk   (clk),
    .rst_n (rst_int_n),
    .req   (req_i),
    .data  (data_i),
    .good  (good),
    .rsp   (rsp),
    .held  (held)
  );

  nib_rx_fwd #(.W(DATA_W)) i_fwd (
    .clk   (clk),
    .rst_n (rst_int_n),
    .rsp   (rsp),
    .held  (held),
    .vld   (fwd_vld_o),
    .data  (fwd_data_o)
  );

  assign resp_o = rsp;

endmodule

// File: rtl/nib_rx_chk.sv
module nib_rx_chk #(
  parameter int unsigned W = 4
) (
  input logic         clk,
  input logic         rst_int_n,
  input logic         req_i,
  input logic [W-1:0] data_i,
  input logic         par_i,
  input logic [1:0]   resp_o,
  input logic         fwd_vld_o,
  input logic [W-1:0] fwd_data_o
);

  localparam logic [1:0] C_IDLE = 2'b00;
  localparam logic [1:0] C_ACK  = 2'b01;
  localparam logic [1:0] C_ERR  = 2'b10;

  // R2
  resp_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    resp_o != 2'b11);

  // R3
  verdict_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_i && resp_o == C_IDLE) |=> (resp_o != C_IDLE));

  // R1
  verdict_matches_parity_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (req_i && resp_o == C_IDLE) |=>
      (resp_o == ((^{$past(data_i), $past(par_i)}) ? C_ERR : C_ACK)));

  // R4
  verdict_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (resp_o != C_IDLE) |=> (resp_o == C_IDLE));

  // R5
  fwd_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (resp_o == C_ACK) |=> fwd_vld_o);

  // R5
  fwd_only_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    fwd_vld_o |-> ($past(resp_o) == C_ACK));

  // R5
  fwd_data_origin_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (resp_o == C_ACK) |=> (fwd_data_o == $past(data_i, 2)));

  // R6
  no_fwd_after_err_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    (resp_o == C_ERR) |=> (!fwd_vld_o && $stable(fwd_data_o)));

  // R9
  fwd_data_hold_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(resp_o) != C_ACK) |-> $stable(fwd_data_o));

endmodule

bind nib_rx nib_rx_chk #(.W(DATA_W)) i_chk (
  .clk        (clk),
  .rst_int_n  (rst_int_n),
  .req_i      (req_i),
  .data_i     (data_i),
  .par_i      (par_i),
  .resp_o     (resp_o),
  .fwd_vld_o  (fwd_vld_o),
  .fwd_data_o (fwd_data_o)
);

// File: tb/test_nib_rx.sv
module test_nib_rx;

  localparam time CLK_P = 20ns;

  logic       clk;
  logic       rst_n;
  logic       req_i;
  logic [3:0] data_i;
  logic       par_i;
  logic [1:0] resp_o;
  logic       fwd_vld_o;
  logic [3:0] fwd_data_o;

  int checks;
  int fails;
  logic [3:0] last_fwd;

  nib_rx i_nib_rx (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_i      (req_i),
    .data_i     (data_i),
    .par_i      (par_i),
    .resp_o     (resp_o),
    .fwd_vld_o  (fwd_vld_o),
    .fwd_data_o (fwd_data_o)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Called at a falling edge; leaves the bench at the falling edge of the forward cycle.
  task automatic xact(input logic [3:0] d, input logic p, input bit hold);
    bit good;
    good   = ((^d) ^ p) == 1'b0;
    req_i  = 1'b1;
    data_i = d;
    par_i  = p;
    @(negedge clk);
    // verdict cycle
    chk("R1/R2 verdict code", resp_o, good ? 1 : 2);
    chk("R5 no strobe in verdict cycle", fwd_vld_o, 0);
    if (!hold) begin
      req_i  = 1'b0;
      data_i = ~d;
      par_i  = ~p;
    end
    @(negedge clk);
    // forward cycle
    chk(hold ? "R4 held request ignored" : "R3 verdict lasts one cycle", resp_o, 0);
    chk(good ? "R5 strobe after ack" : "R6 no strobe after error", fwd_vld_o, good ? 1 : 0);
    if (good) last_fwd = d;
    chk(good ? "R5 forwarded nibble" : "R6/R9 data kept", fwd_data_o, last_fwd);
    req_i = 1'b0;
  endtask

  initial begin
    checks   = 0;
    fails    = 0;
    last_fwd = 4'h0;
    rst_n    = 1'b0;
    req_i    = 1'b0;
    data_i   = 4'h0;
    par_i    = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 reset resp", resp_o, 0);
    chk("R8 reset strobe", fwd_vld_o, 0);
    chk("R8 reset data", fwd_data_o, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // Sweep every data/parity pair with mixed holding, gaps and back-to-back (R7).
    for (int i = 0; i < 32; i++) begin
      xact(i[3:0], i[4], (i % 3) == 0);
      if ((i % 4) == 1) @(negedge clk);
    end

    // R9: quiet cycles with noisy data but no request leave everything alone
    data_i = 4'hA;
    par_i  = 1'b1;
    repeat (3) begin
      @(negedge clk);
      chk("R9 quiet strobe", fwd_vld_o, 0);
      chk("R9 quiet data", fwd_data_o, last_fwd);
      chk("R3 quiet resp", resp_o, 0);
    end

    // R7: explicit back-to-back pair, second piece sampled in the forward cycle
    xact(4'h6, 1'b0, 1'b0);
    xact(4'h7, 1'b1, 1'b0);

    // R8: asynchronous reset in the middle of a verdict
    req_i  = 1'b1;
    data_i = 4'h9;
    par_i  = 1'b0;
    @(negedge clk);
    chk("R8 pre-reset verdict", resp_o, 1);
    #3ns;
    rst_n = 1'b0;
    #1ns;
    chk("R8 async clear resp", resp_o, 0);
    chk("R8 async clear strobe", fwd_vld_o, 0);
    chk("R8 async clear data", fwd_data_o, 0);
    req_i = 1'b0;
    last_fwd = 4'h0;
    @(negedge clk);
    chk("R8 no forward after reset", fwd_vld_o, 0);
    rst_n = 1'b1;
    // request before internal release is not taken
    req_i  = 1'b1;
    data_i = 4'h3;
    par_i  = 1'b0;
    @(negedge clk);
    chk("R8 request ignored during release", resp_o, 0);
    req_i = 1'b0;
    repeat (2) @(negedge clk);
    xact(4'hF, 1'b0, 1'b1);
    xact(4'h1, 1'b0, 1'b0);

    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule